// File: doc/BRIEF.md
# Secondary Interrupt Controller with Per-Line Pass-Through

This block gathers 32 level-sensitive interrupt requests and reduces them to one combined request on output line 31. That request is high whenever at least one active input is also enabled. A software-raised interrupt is held in a latch and merged into input bit 0, so firmware can trigger the combined request itself.

Alongside the combined path, inputs 21 through 30 can each be routed straight to the output line with the same number. This lets an upstream controller see those sources individually. A pass-through line copies its input level for as long as its pass-through bit is set, and it is driven low once the bit is cleared.

Software reaches the block over a word-addressed port. It asserts a request for one cycle with a write strobe, a word index and 32-bit data. Read data appears on the following cycle. All outputs are registered and follow their inputs or register state one clock later.

Top module: `sic_passthru_ctrl`

## Requirements
- R1: After synchronous reset the enable mask, the pass-through enables, the software latch, every output line and the read data are all zero.
- R2: Output line 31 is high one clock after a cycle in which (raw levels AND enable mask) is nonzero, and low one clock after a cycle in which it is zero.
- R3: A read of word index 0 returns raw AND enable, index 1 returns the raw levels, and index 2 returns the enable mask. Data is returned on the cycle after the request, and read data is zero in any cycle that follows no read.
- R4: A write to index 2 ORs the data into the enable mask. A write to index 3 clears each enable bit that is written as 1.
- R5: A write of any nonzero value to index 4 sets the software latch, and a nonzero write to index 5 clears it. Zero writes to either index change nothing. Raw bit 0 equals input 0 OR the latch, and a read of index 4 returns raw bit 0 in bit 0 with all other bits zero.
- R6: A write to index 8 ORs the data, limited to bits 21..30 (mask 0x7FE00000), into the pass-through enables. A write to index 9 clears each pass-through bit written as 1. A read of index 8 returns the pass-through enables.
- R7: For each line n in 21..30, output n one clock later equals input n while pass-through bit n is set, and is low while it is clear.
- R8: Output lines 0..20 stay low whatever the inputs and registers hold.
- R9: Reads of any index other than 0, 1, 2, 4 and 8 return zero. Writes to any index other than 2, 3, 4, 5, 8 and 9 change no state. The whole 10-bit word index is decoded, so higher aliases do not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Word index inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read request |
| irq_in | input | 32 | Level-sensitive interrupt inputs |
| irq_out | output | 32 | Line 31 combined request, lines 21..30 pass-through, others low |

## Verification
The bench attacks the pass-through set mask by writing all ones to index 8. A design that skipped the limit would report stray bits on read-back and would drive lines 0..20 from inputs that are held high. Zero writes to the software set and clear registers are tested, and a design that acted on the write strobe alone would flip the latch and with it raw bit 0 and line 31. A nonzero write to the clear register uses a value whose bit 0 is zero, so a design that decoded only bit 0 would leave the latch set. Writes to an alias whose low index bits equal the enable-set index would change the mask in a design with partial decode. Clearing a pass-through bit while its input is high must pull that line low rather than freeze it, and the cycle-by-cycle model flags any output one cycle early or late.

// File: rtl/sic_pkg.sv
package sic_pkg;
  typedef enum logic [3:0] {
    IDX_MSTAT = 4'd0,
    IDX_RAW   = 4'd1,
    IDX_ENSET = 4'd2,
    IDX_ENCLR = 4'd3,
    IDX_SWSET = 4'd4,
    IDX_SWCLR = 4'd5,
    IDX_PTSET = 4'd8,
    IDX_PTCLR = 4'd9
  } reg_idx_e;
endpackage

// File: rtl/sic_regs.sv
module sic_regs #(
  parameter int unsigned N     = 32,
  parameter int unsigned AW    = 10,
  parameter int unsigned PT_LO = 21,
  parameter int unsigned PT_HI = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic [N-1:0]  irq_in,
  output logic [N-1:0]  raw_lv,
  output logic [N-1:0]  en_mask,
  output logic [N-1:0]  pt_en,
  output logic [31:0]   bus_rdata
);
  import sic_pkg::*;

  function automatic logic [N-1:0] range_mask();
    logic [N-1:0] m;
    m = '0;
    for (int i = 0; i < int'(N); i++)
      if (i >= int'(PT_LO) && i <= int'(PT_HI)) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [N-1:0] PT_MASK = range_mask();

  logic          swi_q;
  logic          page_hit;
  logic          wr_hit;
  logic          rd_hit;
  logic [3:0]    idx;
  logic [N-1:0]  wval;

  assign idx      = bus_addr[3:0];
  assign page_hit = (bus_addr[AW-1:4] == '0);
  assign wr_hit   = bus_req && bus_we && page_hit;
  assign rd_hit   = bus_req && !bus_we && page_hit;
  assign wval     = bus_wdata[N-1:0];
  assign raw_lv   = irq_in | {{(N-1){1'b0}}, swi_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_mask <= '0;
      pt_en   <= '0;
      swi_q   <= 1'b0;
    end else if (wr_hit) begin
      case (idx)
        IDX_ENSET: en_mask <= en_mask | wval;
        IDX_ENCLR: en_mask <= en_mask & ~wval;
        IDX_SWSET: if (bus_wdata != '0) swi_q <= 1'b1;
        IDX_SWCLR: if (bus_wdata != '0) swi_q <= 1'b0;
        IDX_PTSET: pt_en   <= pt_en | (wval & PT_MASK);
        IDX_PTCLR: pt_en   <= pt_en & ~wval;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (rd_hit) begin
        case (idx)
          IDX_MSTAT: bus_rdata <= 32'(raw_lv & en_mask);
          IDX_RAW:   bus_rdata <= 32'(raw_lv);
          IDX_ENSET: bus_rdata <= 32'(en_mask);
          IDX_SWSET: bus_rdata <= {31'b0, raw_lv[0]};
          IDX_PTSET: bus_rdata <= 32'(pt_en);
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  p_enset_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == AW'(2)) |=>
      en_mask == ($past(en_mask) | $past(bus_wdata[N-1:0])));

  p_enclr_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == AW'(3)) |=>
      en_mask == ($past(en_mask) & ~$past(bus_wdata[N-1:0])));

  p_swset_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == AW'(4) && bus_wdata != '0) |=> raw_lv[0]);

  p_ptset_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == AW'(8)) |=>
      pt_en == ($past(pt_en) | ($past(bus_wdata[N-1:0]) & PT_MASK)));

  p_rd_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && !bus_we) |=> bus_rdata == '0);

  p_undef_wr_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && !(bus_addr == AW'(2) || bus_addr == AW'(3) ||
     bus_addr == AW'(4) || bus_addr == AW'(5) || bus_addr == AW'(8) ||
     bus_addr == AW'(9))) |=> ($stable(en_mask) && $stable(pt_en)));
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int unsigned N     = 32,
  parameter int unsigned PT_LO = 21,
  parameter int unsigned PT_HI = 30,
  parameter int unsigned CMB   = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_lv,
  input  logic [N-1:0] en_mask,
  input  logic [N-1:0] pt_en,
  output logic [N-1:0] irq_out
);
  for (genvar g = 0; g < int'(N); g++) begin : g_line
    if (g == int'(CMB)) begin : g_cmb
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= |(raw_lv & en_mask);
      end
      assign irq_out[g] = q;

      p_comb_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_out[g] == $past(|(raw_lv & en_mask)));
    end else if (g >= int'(PT_LO) && g <= int'(PT_HI)) begin : g_pt
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= pt_en[g] & raw_lv[g];
      end
      assign irq_out[g] = q;

      p_pt_copy_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_out[g] == ($past(pt_en[g]) && $past(raw_lv[g])));
    end else begin : g_off
      assign irq_out[g] = 1'b0;
    end
  end
endmodule

// File: rtl/sic_passthru_ctrl.sv
module sic_passthru_ctrl #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned PT_LO   = 21,
  parameter int unsigned PT_HI   = 30,
  parameter int unsigned CMB     = N_LINES - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [N_LINES-1:0] irq_in,
  output logic [N_LINES-1:0] irq_out
);
  logic [N_LINES-1:0] raw_lv;
  logic [N_LINES-1:0] en_mask;
  logic [N_LINES-1:0] pt_en;

  sic_regs #(.N(N_LINES), .AW(ADDR_W), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_in    (irq_in),
    .raw_lv    (raw_lv),
    .en_mask   (en_mask),
    .pt_en     (pt_en),
    .bus_rdata (bus_rdata)
  );

  sic_route #(.N(N_LINES), .PT_LO(PT_LO), .PT_HI(PT_HI), .CMB(CMB)) u_route (
    .clk     (clk),
    .rst     (rst),
    .raw_lv  (raw_lv),
    .en_mask (en_mask),
    .pt_en   (pt_en),
    .irq_out (irq_out)
  );
endmodule

// File: tb/sic_passthru_ctrl_tb.sv
`timescale 1ns/1ps
module sic_passthru_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic [31:0] irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sic_passthru_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  // behavioural reference model
  logic [31:0] m_en, m_pt, m_out, m_rd;
  logic        m_swi;
  always @(posedge clk) begin
    logic [31:0] raw;
    raw = irq_in | {31'b0, m_swi};
    if (rst) begin
      m_en <= 0; m_pt <= 0; m_swi <= 0; m_out <= 0; m_rd <= 0;
    end else begin
      m_out <= ((raw & m_en) != 0 ? 32'h8000_0000 : 32'h0) | (m_pt & irq_in);
      m_rd  <= 0;
      if (bus_req && !bus_we) begin
        if (bus_addr == 0)      m_rd <= raw & m_en;
        else if (bus_addr == 1) m_rd <= raw;
        else if (bus_addr == 2) m_rd <= m_en;
        else if (bus_addr == 4) m_rd <= {31'b0, raw[0]};
        else if (bus_addr == 8) m_rd <= m_pt;
      end
      if (bus_req && bus_we) begin
        if (bus_addr == 2)      m_en <= m_en | bus_wdata;
        else if (bus_addr == 3) m_en <= m_en & ~bus_wdata;
        else if (bus_addr == 4) begin if (bus_wdata != 0) m_swi <= 1; end
        else if (bus_addr == 5) begin if (bus_wdata != 0) m_swi <= 0; end
        else if (bus_addr == 8) m_pt <= m_pt | (bus_wdata & 32'h7FE0_0000);
        else if (bus_addr == 9) m_pt <= m_pt & ~bus_wdata;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 line31 vs model", {31'b0, irq_out[31]}, {31'b0, m_out[31]});
      check("R7 lines21-30 vs model", irq_out & 32'h7FE0_0000, m_out & 32'h7FE0_0000);
      check("R8 lines0-20 vs model", irq_out & 32'h001F_FFFF, 32'h0);
      check("R3 rdata vs model", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string req);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    check(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 0;
    check("R1 outputs after reset", irq_out, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    rd(10'd2, 32'h0, "R1 enable mask reset");
    rd(10'd8, 32'h0, "R1 pass-through reset");
    rd(10'd1, 32'h0, "R1 software latch reset");

    irq_in = 32'h0000_00F0;
    idle(1);
    rd(10'd1, 32'h0000_00F0, "R3 raw status");
    rd(10'd0, 32'h0, "R3 masked status empty");
    check("R2 line31 low with no enables", {31'b0, irq_out[31]}, 32'h0);

    wr(10'd2, 32'h0000_0030);
    wr(10'd2, 32'h0000_0100);
    rd(10'd2, 32'h0000_0130, "R4 enable set ORs");
    rd(10'd0, 32'h0000_0030, "R3 masked status");
    check("R2 line31 high", {31'b0, irq_out[31]}, 32'h1);
    wr(10'd3, 32'h0000_0010);
    rd(10'd2, 32'h0000_0120, "R4 enable clear");
    wr(10'd3, 32'h0000_0020);
    idle(2);
    check("R2 line31 low after clear", {31'b0, irq_out[31]}, 32'h0);

    wr(10'd4, 32'h0);
    rd(10'd1, 32'h0000_00F0, "R5 zero set write ignored");
    wr(10'd4, 32'h0000_0500);
    rd(10'd1, 32'h0000_00F1, "R5 latch in raw bit0");
    rd(10'd4, 32'h0000_0001, "R5 index4 reads bit0");
    wr(10'd2, 32'h0000_0001);
    idle(2);
    check("R5 latch drives line31", {31'b0, irq_out[31]}, 32'h1);
    wr(10'd5, 32'h0);
    rd(10'd4, 32'h0000_0001, "R5 zero clear write ignored");
    wr(10'd5, 32'h0000_0080);
    rd(10'd4, 32'h0, "R5 latch cleared");
    idle(1);
    check("R2 line31 follows latch clear", {31'b0, irq_out[31]}, 32'h0);

    wr(10'd8, 32'hFFFF_FFFF);
    rd(10'd8, 32'h7FE0_0000, "R6 pass-through set limited");
    irq_in = 32'h5AA0_00F0 | 32'h001F_FF00;
    idle(2);
    check("R7 pass-through copy", irq_out & 32'h7FFF_FFFF, 32'h5AA0_0000);
    check("R8 low lines stay low", irq_out & 32'h001F_FFFF, 32'h0);
    wr(10'd9, 32'h0060_0000);
    rd(10'd8, 32'h7F80_0000, "R6 pass-through clear");
    check("R7 cleared line driven low", irq_out & 32'h0060_0000, 32'h0);
    irq_in = 32'h2480_0000;
    idle(2);
    check("R7 follows input change", irq_out & 32'h7FE0_0000, 32'h2480_0000);

    wr(10'd6, 32'hFFFF_FFFF);
    wr(10'd7, 32'hFFFF_FFFF);
    wr(10'd10, 32'hFFFF_FFFF);
    wr(10'h3F2, 32'hFFFF_FFFF);
    wr(10'h3F8, 32'hFFFF_FFFF);
    rd(10'd2, 32'h0000_0101, "R9 enables unchanged");
    rd(10'd8, 32'h7F80_0000, "R9 pass-through unchanged");
    rd(10'd6, 32'h0, "R9 undefined read");
    rd(10'h3F1, 32'h0, "R9 alias read");
    rd(10'd3, 32'h0, "R9 write-only index read");

    idle(3);
    rst = 1;
    idle(2);
    rst = 0;
    check("R1 outputs after second reset", irq_out, 32'h0);
    rd(10'd8, 32'h0, "R1 pass-through after second reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule